// File: doc/BRIEF.md
# Bus Transaction Firewall with Address Remap

This block sits between one bus master port and the shared interconnect. It checks every read and write against a table of programmable regions. Each region holds an inclusive address window, a target base used for remapping, a secure-only attribute and a mask of the master IDs that may use it. A transaction that passes goes downstream one cycle later with its address remapped. A transaction that fails is never forwarded. Instead, the block answers it with an error response and records it in a sticky fault register.

A device lifecycle input sets what happens to an access that matches no region. In the development state such an access passes with its address unchanged. In the secure state it is refused until regions are set up. Only one supervisor master ID may write the region table. A write from any other ID is dropped and flagged. The upstream bus is single-outstanding: the master issues a one-cycle request pulse and waits for the response.

Top module: `bus_firewall`

## Requirements
- R1: After a synchronous reset, all regions are disabled, and `rsp_valid`, `dn_valid`, `cfg_reject` and `flt_valid` are 0.
- R2: A region matches when it is enabled and `base <= req_addr <= limit` (both bounds inclusive). When several regions match, the lowest-numbered one alone decides the outcome.
- R3: A transaction inside a matching region passes only if bit `req_mid` of that region's master mask is set.
- R4: A transaction with `req_nonsec = 1` is blocked when its matching region is secure-only.
- R5: A passing transaction inside a region appears on the downstream port one cycle after the request. Its address is `req_addr - base + target`, computed modulo 2^32. Write flag, write data, non-secure flag and master ID are copied unchanged.
- R6: A transaction that matches no region passes with its address unchanged when `lifecycle_secure = 0`, and is blocked when `lifecycle_secure = 1`.
- R7: A blocked transaction produces `rsp_valid = 1`, `rsp_err = 1` and `rsp_rdata = 0` one cycle after the request, and `dn_valid` stays 0.
- R8: A configuration write takes effect only when `cfg_mid` equals the supervisor ID (default 7).
  - Field codes on `cfg_field`:
    - 0 = base
    - 1 = limit
    - 2 = target
    - 3 = attributes. Bit 0 is enable, bit 1 is secure-only, and bits 8 and up hold the master mask.
  - A write from any other ID leaves the table unchanged and raises `cfg_reject` for one cycle, in the cycle after the write.
- R9: The first blocked transaction after reset is captured in `flt_addr` and `flt_mid`, with `flt_valid = 1`. These values hold until the next reset.
- R10: The downstream response (`dn_rsp_valid`, `dn_rsp_err`, `dn_rsp_rdata`) is passed to the upstream response in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lifecycle_secure | input | 1 | 0 = development (open default), 1 = secure (closed default) |
| req_valid | input | 1 | Request pulse from the master |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nonsec | input | 1 | Non-secure flag of the request |
| req_mid | input | 3 | Master ID of the request |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response to the master |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| dn_valid | output | 1 | Forwarded request |
| dn_write | output | 1 | Forwarded write flag |
| dn_nonsec | output | 1 | Forwarded non-secure flag |
| dn_mid | output | 3 | Forwarded master ID |
| dn_addr | output | 32 | Remapped address |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rsp_valid | input | 1 | Downstream response |
| dn_rsp_err | input | 1 | Downstream error |
| dn_rsp_rdata | input | 32 | Downstream read data |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_mid | input | 3 | Master ID of the configuration write |
| cfg_region | input | 3 | Region index |
| cfg_field | input | 2 | Field code (see R8) |
| cfg_wdata | input | 32 | Field value |
| cfg_reject | output | 1 | Pulse: unauthorised configuration write dropped |
| flt_valid | output | 1 | Sticky: a transaction was blocked |
| flt_addr | output | 32 | Address of the first blocked transaction |
| flt_mid | output | 3 | Master ID of the first blocked transaction |

## Verification
The hardest situation to reach is an overlap: one address inside two regions whose rules disagree. The low-numbered region refuses the master, while the higher, larger one would accept it. The stimulus programs such a pair, then sends the same address from a master that only the second region admits. It then disables the first region and repeats the access to show that the second region takes over. The remap wrap-around case is reached the same way, with a region whose target base makes the 32-bit sum overflow.

// File: rtl/fw_pkg.sv
// fw_pkg: shared widths, field codes and the region record of the firewall.
// Assumes a 32-bit address space and master IDs of MID_W bits.
package fw_pkg;
    localparam int ADDR_W  = 32;
    localparam int MID_W   = 3;
    localparam int NUM_MID = 1 << MID_W;

    typedef enum logic [1:0] {
        FLD_BASE   = 2'd0,
        FLD_LIMIT  = 2'd1,
        FLD_TARGET = 2'd2,
        FLD_ATTR   = 2'd3
    } cfg_field_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  limit;
        logic [ADDR_W-1:0]  target;
        logic [NUM_MID-1:0] mask;
        logic               sec_only;
        logic               en;
    } region_t;
endpackage

// File: rtl/fw_region_table.sv
// fw_region_table: holds the region records and applies configuration writes.
// Only the supervisor master ID may write. Other writes are dropped and
// flagged on cfg_reject one cycle later. All regions reset to disabled.
module fw_region_table
    import fw_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int SUPER_MID   = 7,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [MID_W-1:0]  cfg_mid,
    input  logic [IDX_W-1:0]  cfg_region,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output region_t           regions [NUM_REGIONS],
    output logic              cfg_reject
);
    logic cfg_ok;
    assign cfg_ok = cfg_valid && (cfg_mid == MID_W'(SUPER_MID));

    // Flag a dropped, unauthorised configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_reject <= 1'b0;
        else        cfg_reject <= cfg_valid && !cfg_ok;
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        // Update one field of region g on an authorised write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regions[g] <= '0;
            end else if (cfg_ok && cfg_region == IDX_W'(g)) begin
                case (cfg_field_e'(cfg_field))
                    FLD_BASE:   regions[g].base   <= cfg_wdata;
                    FLD_LIMIT:  regions[g].limit  <= cfg_wdata;
                    FLD_TARGET: regions[g].target <= cfg_wdata;
                    default: begin
                        regions[g].en       <= cfg_wdata[0];
                        regions[g].sec_only <= cfg_wdata[1];
                        regions[g].mask     <= cfg_wdata[8 +: NUM_MID];
                    end
                endcase
            end
        end

        // R8
        tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_valid && cfg_mid != MID_W'(SUPER_MID)) |=> $stable(regions[g]));
    end
endmodule

// File: rtl/fw_match.sv
// fw_match: combinational region lookup. Finds the lowest-numbered enabled
// region whose inclusive window holds the address, then reports hit, the
// access verdict, the secure-only attribute and the remapped address.
module fw_match
    import fw_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  region_t            regions [NUM_REGIONS],
    input  logic [ADDR_W-1:0]  addr,
    input  logic               nonsec,
    input  logic [MID_W-1:0]   mid,
    output logic [NUM_REGIONS-1:0] sel_vec,
    output logic               hit,
    output logic               hit_sec,
    output logic               allow,
    output logic [ADDR_W-1:0]  xlat_addr
);
    logic [NUM_REGIONS-1:0] in_win;
    region_t                sel_r;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        assign in_win[g] = regions[g].en && (addr >= regions[g].base)
                           && (addr <= regions[g].limit);
    end

    // Priority pick: the lowest index wins, then derive the verdict.
    always_comb begin
        sel_vec = '0;
        hit     = 1'b0;
        sel_r   = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (in_win[i] && !hit) begin
                sel_vec[i] = 1'b1;
                hit        = 1'b1;
                sel_r      = regions[i];
            end
        end
        hit_sec   = sel_r.sec_only;
        allow     = sel_r.mask[mid] && !(nonsec && sel_r.sec_only);
        xlat_addr = addr - sel_r.base + sel_r.target;
    end
endmodule

// File: rtl/fw_fault_log.sv
// fw_fault_log: captures the address and master ID of the first blocked
// transaction after reset and holds them until the next reset.
module fw_fault_log
    import fw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blocked,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MID_W-1:0]  mid,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [MID_W-1:0]  flt_mid
);
    // Record the first fault only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_valid <= 1'b0;
            flt_addr  <= '0;
            flt_mid   <= '0;
        end else if (blocked && !flt_valid) begin
            flt_valid <= 1'b1;
            flt_addr  <= addr;
            flt_mid   <= mid;
        end
    end

    // R9
    flt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> (flt_valid && $stable(flt_addr) && $stable(flt_mid)));
endmodule

// File: rtl/bus_firewall.sv
// bus_firewall: checks each request against the region table, forwards a
// passing one with a remapped address one cycle later, and answers a
// blocked one with an error one cycle later. Assumes at most one request
// is outstanding, so the error and the downstream response never collide.
module bus_firewall
    import fw_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int SUPER_MID   = 7,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lifecycle_secure,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_nonsec,
    input  logic [MID_W-1:0]  req_mid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic              dn_nonsec,
    output logic [MID_W-1:0]  dn_mid,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [ADDR_W-1:0] dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic              dn_rsp_err,
    input  logic [ADDR_W-1:0] dn_rsp_rdata,
    input  logic              cfg_valid,
    input  logic [MID_W-1:0]  cfg_mid,
    input  logic [IDX_W-1:0]  cfg_region,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              cfg_reject,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [MID_W-1:0]  flt_mid
);
    region_t                regions [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] m_sel;
    logic                   m_hit, m_hit_sec, m_allow;
    logic [ADDR_W-1:0]      m_xlat;
    logic                   pass, err_q;
    logic [ADDR_W-1:0]      fwd_addr;

    fw_region_table #(.NUM_REGIONS(NUM_REGIONS), .SUPER_MID(SUPER_MID)) u_tbl (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_mid(cfg_mid),
        .cfg_region(cfg_region), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .regions(regions), .cfg_reject(cfg_reject)
    );

    fw_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .regions(regions), .addr(req_addr), .nonsec(req_nonsec), .mid(req_mid),
        .sel_vec(m_sel), .hit(m_hit), .hit_sec(m_hit_sec), .allow(m_allow),
        .xlat_addr(m_xlat)
    );

    // Verdict: the matching region decides; otherwise the lifecycle default applies.
    always_comb begin
        pass     = m_hit ? m_allow : !lifecycle_secure;
        fwd_addr = m_hit ? m_xlat  : req_addr;
    end

    // Register the forwarded request or the pending error response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid  <= 1'b0;
            err_q     <= 1'b0;
            dn_write  <= 1'b0;
            dn_nonsec <= 1'b0;
            dn_mid    <= '0;
            dn_addr   <= '0;
            dn_wdata  <= '0;
        end else begin
            dn_valid <= req_valid && pass;
            err_q    <= req_valid && !pass;
            if (req_valid && pass) begin
                dn_write  <= req_write;
                dn_nonsec <= req_nonsec;
                dn_mid    <= req_mid;
                dn_addr   <= fwd_addr;
                dn_wdata  <= req_wdata;
            end
        end
    end

    // Merge the local error with the downstream response.
    always_comb begin
        rsp_valid = err_q | dn_rsp_valid;
        rsp_err   = err_q | (dn_rsp_valid & dn_rsp_err);
        rsp_rdata = err_q ? '0 : dn_rsp_rdata;
    end

    fw_fault_log u_flt (
        .clk(clk), .rst_n(rst_n), .blocked(req_valid && !pass),
        .addr(req_addr), .mid(req_mid),
        .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_mid(flt_mid)
    );

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_sel) && (m_hit == (m_sel != '0)));
    // R4
    sec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nonsec && m_hit && m_hit_sec) |=> (rsp_err && !dn_valid));
    // R6
    closed_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !m_hit && lifecycle_secure) |=> (rsp_valid && !dn_valid));
    // R7
    err_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && !dn_rsp_valid) |-> !dn_valid);
    // R5
    fwd_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> ($past(req_valid) && dn_mid == $past(req_mid)));
endmodule

// File: tb/sim_bus_firewall.sv
// sim_bus_firewall: vector table walk plus directed tests for bus_firewall.
module sim_bus_firewall;
    import fw_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lifecycle_secure = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_nonsec = 1'b0;
    logic [2:0]  req_mid = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic dn_valid, dn_write, dn_nonsec;
    logic [2:0]  dn_mid;
    logic [31:0] dn_addr, dn_wdata;
    logic dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
    logic [31:0] dn_rsp_rdata = '0;
    logic cfg_valid = 1'b0;
    logic [2:0]  cfg_mid = '0, cfg_region = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic cfg_reject, flt_valid;
    logic [31:0] flt_addr;
    logic [2:0]  flt_mid;
    logic inject_err = 1'b0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bus_firewall u0 (
        .clk(clk), .rst_n(rst_n), .lifecycle_secure(lifecycle_secure),
        .req_valid(req_valid), .req_write(req_write), .req_nonsec(req_nonsec),
        .req_mid(req_mid), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_nonsec(dn_nonsec),
        .dn_mid(dn_mid), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err),
        .dn_rsp_rdata(dn_rsp_rdata), .cfg_valid(cfg_valid), .cfg_mid(cfg_mid),
        .cfg_region(cfg_region), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .cfg_reject(cfg_reject), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_mid(flt_mid)
    );

    // Downstream model: answers one cycle after a forwarded request, echoing its address.
    always @(posedge clk) begin
        dn_rsp_valid <= dn_valid;
        dn_rsp_err   <= dn_valid && inject_err;
        dn_rsp_rdata <= dn_valid ? dn_addr : 32'h0;
    end

    typedef struct packed {
        logic [3:0]  rq;
        logic        wr;
        logic        ns;
        logic [2:0]  mid;
        logic [31:0] addr;
        logic        ok;
        logic [31:0] xa;
    } vec_t;

    // Region plan: 0 = 1000_0000..0FFF -> 2000_0000, mask {1}
    // 1 = 1000_0000..FFFF -> 3000_0000, secure-only, all masters
    // 2 = 4000_0000..0FFF -> 5000_1000, mask {2,3}; 7 = 4000_1000..1FFF -> 5000_0000, mask {2,3}
    // 3 = 0000_1000..2FFF -> FFFF_F000, mask {0}
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 1'b1, 3'd1, 32'h1000_0010, 1'b1, 32'h2000_0010}, // R2 R5 region 0
        '{4'd3, 1'b0, 1'b0, 3'd2, 32'h1000_0010, 1'b0, 32'h0},         // R3 region 0 wins, mid 2 refused
        '{4'd4, 1'b0, 1'b0, 3'd2, 32'h1000_1004, 1'b1, 32'h3000_1004}, // R4 secure access ok
        '{4'd4, 1'b0, 1'b1, 3'd2, 32'h1000_1004, 1'b0, 32'h0},         // R4 non-secure blocked
        '{4'd2, 1'b0, 1'b1, 3'd3, 32'h4000_0FFC, 1'b1, 32'h5000_1FFC}, // R2 inclusive limit
        '{4'd5, 1'b0, 1'b1, 3'd3, 32'h4000_1000, 1'b1, 32'h5000_0000}, // R5 region 7
        '{4'd5, 1'b1, 1'b1, 3'd2, 32'h4000_1FFF, 1'b1, 32'h5000_0FFF}, // R5 write
        '{4'd3, 1'b0, 1'b1, 3'd4, 32'h4000_0000, 1'b0, 32'h0},         // R3 mid 4 refused
        '{4'd6, 1'b0, 1'b1, 3'd0, 32'h8000_0000, 1'b0, 32'h0},         // R6 closed default
        '{4'd6, 1'b0, 1'b1, 3'd1, 32'h0FFF_FFFC, 1'b0, 32'h0},         // R6 just below base
        '{4'd5, 1'b0, 1'b1, 3'd0, 32'h0000_2010, 1'b1, 32'h0000_0010}  // R5 modulo wrap
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request; checks forwarding or the error response cycle by cycle.
    task automatic access(input logic wr, input logic ns, input logic [2:0] mid,
                          input logic [31:0] addr, input logic ok,
                          input logic [31:0] xa, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_nonsec = ns; req_mid = mid;
        req_addr = addr; req_wdata = addr ^ 32'h5555_AAAA;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (ok) begin
            chk(dn_valid && !rsp_valid, {tag, " forwarded"}, {30'd0, dn_valid, rsp_valid}, 32'h2);
            chk(dn_addr == xa, {tag, " addr"}, dn_addr, xa);
            chk(dn_write == wr && dn_nonsec == ns && dn_mid == mid &&
                dn_wdata == (addr ^ 32'h5555_AAAA), {tag, " fields"}, dn_wdata, addr ^ 32'h5555_AAAA);
            @(posedge clk); #1;
            chk(rsp_valid && rsp_err == inject_err && rsp_rdata == xa,
                {tag, " R10 response"}, rsp_rdata, xa);
        end else begin
            chk(!dn_valid && rsp_valid && rsp_err, {tag, " R7 blocked"},
                {29'd0, dn_valid, rsp_valid, rsp_err}, 32'h3);
            chk(rsp_rdata == 32'h0, {tag, " R7 rdata"}, rsp_rdata, 32'h0);
        end
    endtask

    task automatic cfg(input logic [2:0] mid, input logic [2:0] rg, input logic [1:0] fld,
                       input logic [31:0] data, input logic rej);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_mid = mid; cfg_region = rg; cfg_field = fld; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_valid = 1'b0;
        chk(cfg_reject == rej, "R8 cfg_reject", {31'd0, cfg_reject}, {31'd0, rej});
    endtask

    task automatic region(input logic [2:0] rg, input logic [31:0] b, input logic [31:0] l,
                          input logic [31:0] t, input logic [31:0] a);
        cfg(3'd7, rg, 2'd0, b, 1'b0);
        cfg(3'd7, rg, 2'd1, l, 1'b0);
        cfg(3'd7, rg, 2'd2, t, 1'b0);
        cfg(3'd7, rg, 2'd3, a, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(!rsp_valid && !dn_valid && !cfg_reject && !flt_valid, "R1 reset outputs",
            {28'd0, rsp_valid, dn_valid, cfg_reject, flt_valid}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R6: no region enabled after reset, secure state refuses
        access(1'b0, 1'b1, 3'd0, 32'h1000_0010, 1'b0, 32'h0, "R6 closed before config");
        chk(flt_valid && flt_addr == 32'h1000_0010 && flt_mid == 3'd0, "R9 first fault",
            flt_addr, 32'h1000_0010);

        region(3'd0, 32'h1000_0000, 32'h1000_0FFF, 32'h2000_0000, 32'h0000_0201);
        region(3'd1, 32'h1000_0000, 32'h1000_FFFF, 32'h3000_0000, 32'h0000_FF03);
        region(3'd2, 32'h4000_0000, 32'h4000_0FFF, 32'h5000_1000, 32'h0000_0C01);
        region(3'd7, 32'h4000_1000, 32'h4000_1FFF, 32'h5000_0000, 32'h0000_0C01);
        region(3'd3, 32'h0000_1000, 32'h0000_2FFF, 32'hFFFF_F000, 32'h0000_0101);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].ns, VECS[i].mid, VECS[i].addr, VECS[i].ok,
                   VECS[i].xa, $sformatf("R%0d vector %0d", VECS[i].rq, i));
        end

        // R9: later faults do not overwrite the record
        chk(flt_valid && flt_addr == 32'h1000_0010 && flt_mid == 3'd0, "R9 sticky",
            flt_addr, 32'h1000_0010);

        // R8: a non-supervisor write is dropped; region 0 is unchanged
        cfg(3'd3, 3'd0, 2'd0, 32'h0, 1'b1);
        cfg(3'd6, 3'd0, 2'd3, 32'h0, 1'b1);
        access(1'b0, 1'b1, 3'd1, 32'h1000_0010, 1'b1, 32'h2000_0010, "R8 table unchanged");

        // R10: a downstream error passes straight through
        inject_err = 1'b1;
        access(1'b0, 1'b1, 3'd1, 32'h1000_0020, 1'b1, 32'h2000_0020, "R10 downstream err");
        inject_err = 1'b0;

        // R6: open default in the development state; region rules still hold
        lifecycle_secure = 1'b0;
        access(1'b0, 1'b1, 3'd0, 32'h8000_0000, 1'b1, 32'h8000_0000, "R6 open default");
        access(1'b0, 1'b1, 3'd2, 32'h1000_1004, 1'b0, 32'h0, "R4 still enforced");
        lifecycle_secure = 1'b1;

        // R2: disable region 0, the overlapping region 1 now decides
        cfg(3'd7, 3'd0, 2'd3, 32'h0, 1'b0);
        access(1'b0, 1'b0, 3'd2, 32'h1000_0010, 1'b1, 32'h3000_0010, "R2 fallback to region 1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule